// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps a circular record of every instruction an out-of-order core has issued, in program order. When an instruction is issued it takes a free slot. The slot index is returned as the rename tag that its consumers wait on. Execution units finish in any order and broadcast a tag and a result, which are stored in the matching slot. Retirement happens only at the oldest slot, and only once that slot holds its result. A retiring register operation writes the architectural register file. A retiring store is released to memory. A retiring branch that was predicted correctly leaves without any visible write.

When the oldest slot carries a fault mark, the buffer discards every slot and raises a one-cycle flush that names the faulting tag. A fault mark means an exception, or a mispredicted branch. Because of this, architectural state reflects exactly the instructions older than the faulting one. A rename-stage lookup port searches for the youngest in-flight producer of a register. It returns the producer's value if it has completed, or its tag if it has not.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, the next `alloc_tag` is 0, and `cm_reg_we`, `cm_st_release`, `flush_o` and `lk_hit` are all 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) is given `alloc_tag` equal to the current tail index. Successive allocations receive consecutive tags that wrap from DEPTH-1 back to 0.
- R3: With DEPTH slots occupied, `alloc_ready` is 0 and a request made in that state is not recorded. Once the oldest slot retires, the next accepted allocation takes the tag the oldest slot had.
- R4: A writeback (`wb_valid`, `wb_tag`, `wb_value`, `wb_fault`) marks its in-flight slot complete. A completed younger slot produces no retirement while an older slot is still waiting.
- R5: When the oldest slot is a register operation (`alloc_kind` 0) and has completed without a fault, `cm_reg_we` is high for one cycle with its `cm_dest`, `cm_value` and `cm_tag`. Retirements occur at most once per cycle, in program order.
- R6: A store (`alloc_kind` 1) is released only when it is the oldest slot. `cm_st_release` is high with the stored value on `cm_value`, and `cm_reg_we` stays low.
- R7: A branch (`alloc_kind` 2) that completes without a fault retires with neither `cm_reg_we` nor `cm_st_release` asserted.
- R8: When the oldest slot completes with `wb_fault` set, `flush_o` is high for one cycle with `flush_tag` equal to that slot's tag, and no write is made. After the flush the buffer is empty and tags restart at 0.
- R9: A fault on a younger slot takes effect only when that slot becomes the oldest. Every older slot retires normally before the flush.
- R10: A writeback whose tag names a slot that is not in flight has no effect. A later allocation into that slot starts out incomplete.
- R11: `lk_hit` reports whether any in-flight register operation writes `lk_reg`. If so, `lk_tag` is the tag of the youngest such operation, and `lk_ready` together with `lk_value` give its result once it has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to record a new instruction |
| alloc_kind | input | 2 | 0 register op, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register of the new instruction |
| alloc_ready | output | 1 | A slot is free and no flush is under way |
| alloc_tag | output | TAG_W | Tag given to the instruction being allocated |
| wb_valid | input | 1 | Result broadcast present |
| wb_tag | input | TAG_W | Tag of the broadcast result |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Result carries an exception or a misprediction |
| lk_reg | input | REG_W | Source register to look up |
| lk_hit | output | 1 | An in-flight producer of lk_reg exists |
| lk_ready | output | 1 | That producer has completed |
| lk_tag | output | TAG_W | Tag of the youngest producer |
| lk_value | output | DATA_W | Its result, valid when lk_ready is high |
| cm_reg_we | output | 1 | Register write from the oldest slot |
| cm_st_release | output | 1 | Store released to memory from the oldest slot |
| cm_dest | output | REG_W | Destination of the retiring slot |
| cm_value | output | DATA_W | Value of the retiring slot |
| cm_tag | output | TAG_W | Tag of the oldest slot |
| flush_o | output | 1 | Whole buffer discarded this cycle |
| flush_tag | output | TAG_W | Tag of the faulting slot |

## Verification
Results are returned in three orders. In-order return shows retirement keeping up one per cycle. Reverse order shows that completed younger slots wait behind an unfinished head. Return into a stray slot shows that an idle slot ignores broadcasts. A run that fills the buffer, tries one more allocation and then retires shows both the refusal and the tag wrap. Faults placed at the head and on a younger slot, together with a mix of store, branch and register kinds, separate a flush from an ordinary retirement and the three kinds of retirement from each other.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } rob_kind_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter  int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_alloc,
    input  logic             do_retire,
    input  logic             do_flush,
    output logic [TAG_W-1:0] head_idx,
    output logic [TAG_W-1:0] tail_idx,
    output logic             full
);

    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (do_flush) begin
            st_d = '0;
        end else begin
            if (do_alloc)  st_d.tail = step(st_q.tail);
            if (do_retire) st_d.head = step(st_q.head);
            if (do_alloc && !do_retire)
                st_d.count = st_q.count + CNT_W'(1);
            else if (!do_alloc && do_retire)
                st_d.count = st_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_idx = st_q.head;
    assign tail_idx = st_q.tail;
    assign full     = (st_q.count == CNT_W'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_alloc && full && !do_retire));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    assert_retire_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_retire |-> (st_q.count != '0));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> (st_q.count == '0 && st_q.head == '0 && st_q.tail == '0));

endmodule

// File: rtl/rob_slots.sv
module rob_slots
    import rob_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int REG_W  = 5,
    parameter  int DATA_W = 32,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int AGE_W  = TAG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  rob_kind_e         alloc_kind,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_fault,
    input  logic              retire_en,
    input  logic              flush,
    input  logic [TAG_W-1:0]  head_idx,
    output logic              head_valid,
    output logic              head_done,
    output logic              head_fault,
    output rob_kind_e         head_kind,
    output logic [REG_W-1:0]  head_dest,
    output logic [DATA_W-1:0] head_value,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_hit,
    output logic              lk_ready,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_value
);

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              fault;
        rob_kind_e         kind;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
    } slot_t;

    slot_t slot_q [DEPTH];
    slot_t slot_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
            if (flush) begin
                slot_d[i].valid = 1'b0;
                slot_d[i].done  = 1'b0;
            end else begin
                if (retire_en && head_idx == TAG_W'(i)) begin
                    slot_d[i].valid = 1'b0;
                    slot_d[i].done  = 1'b0;
                end
                if (wb_en && wb_idx == TAG_W'(i) && slot_q[i].valid) begin
                    slot_d[i].done  = 1'b1;
                    slot_d[i].fault = wb_fault;
                    slot_d[i].value = wb_value;
                end
                if (alloc_en && alloc_idx == TAG_W'(i)) begin
                    slot_d[i].valid = 1'b1;
                    slot_d[i].done  = 1'b0;
                    slot_d[i].fault = 1'b0;
                    slot_d[i].kind  = alloc_kind;
                    slot_d[i].dest  = alloc_dest;
                    slot_d[i].value = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign head_valid = slot_q[head_idx].valid;
    assign head_done  = slot_q[head_idx].done;
    assign head_fault = slot_q[head_idx].fault;
    assign head_kind  = slot_q[head_idx].kind;
    assign head_dest  = slot_q[head_idx].dest;
    assign head_value = slot_q[head_idx].value;

    // per-slot match flag and distance from the oldest slot
    logic             match_w [DEPTH];
    logic [AGE_W-1:0] age_w   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign match_w[g] = slot_q[g].valid && (slot_q[g].kind == KIND_REG)
                            && (slot_q[g].dest == lk_reg);
        assign age_w[g]   = (TAG_W'(g) >= head_idx)
                            ? AGE_W'(g) - {1'b0, head_idx}
                            : AGE_W'(g) + AGE_W'(DEPTH) - {1'b0, head_idx};
    end

    always_comb begin
        logic [AGE_W-1:0] best_age;
        lk_hit   = 1'b0;
        lk_tag   = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_w[i] && (!lk_hit || age_w[i] > best_age)) begin
                lk_hit   = 1'b1;
                lk_tag   = TAG_W'(i);
                best_age = age_w[i];
            end
        end
        lk_ready = lk_hit && slot_q[lk_tag].done;
        lk_value = slot_q[lk_tag].value;
    end

    assert_alloc_free_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !slot_q[alloc_idx].valid);

    assert_wb_marks_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && slot_q[wb_idx].valid && !flush) |=> slot_q[$past(wb_idx)].done);

    assert_stray_wb_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !slot_q[wb_idx].valid) |=> !slot_q[$past(wb_idx)].done);

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int REG_W  = 5,
    parameter  int DATA_W = 32,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [REG_W-1:0]  alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_fault,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_hit,
    output logic              lk_ready,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_value,
    output logic              cm_reg_we,
    output logic              cm_st_release,
    output logic [REG_W-1:0]  cm_dest,
    output logic [DATA_W-1:0] cm_value,
    output logic [TAG_W-1:0]  cm_tag,
    output logic              flush_o,
    output logic [TAG_W-1:0]  flush_tag
);

    logic [TAG_W-1:0]  head_idx, tail_idx;
    logic              full;
    logic              do_alloc, do_retire;
    logic              head_valid, head_done, head_fault;
    rob_kind_e         head_kind;
    logic [REG_W-1:0]  head_dest;
    logic [DATA_W-1:0] head_value;

    // retirement decision for the oldest slot
    always_comb begin
        do_retire     = head_valid && head_done && !head_fault;
        flush_o       = head_valid && head_done && head_fault;
        cm_reg_we     = do_retire && (head_kind == KIND_REG);
        cm_st_release = do_retire && (head_kind == KIND_STORE);
        alloc_ready   = !full && !flush_o;
        do_alloc      = alloc_valid && alloc_ready;
    end

    assign alloc_tag = tail_idx;
    assign cm_dest   = head_dest;
    assign cm_value  = head_value;
    assign cm_tag    = head_idx;
    assign flush_tag = head_idx;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_alloc  (do_alloc),
        .do_retire (do_retire),
        .do_flush  (flush_o),
        .head_idx  (head_idx),
        .tail_idx  (tail_idx),
        .full      (full)
    );

    rob_slots #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (do_alloc),
        .alloc_idx  (tail_idx),
        .alloc_kind (rob_kind_e'(alloc_kind)),
        .alloc_dest (alloc_dest),
        .wb_en      (wb_valid),
        .wb_idx     (wb_tag),
        .wb_value   (wb_value),
        .wb_fault   (wb_fault),
        .retire_en  (do_retire),
        .flush      (flush_o),
        .head_idx   (head_idx),
        .head_valid (head_valid),
        .head_done  (head_done),
        .head_fault (head_fault),
        .head_kind  (head_kind),
        .head_dest  (head_dest),
        .head_value (head_value),
        .lk_reg     (lk_reg),
        .lk_hit     (lk_hit),
        .lk_ready   (lk_ready),
        .lk_tag     (lk_tag),
        .lk_value   (lk_value)
    );

    assert_commit_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_reg_we || cm_st_release) |=> (cm_tag != $past(cm_tag)));

    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (!cm_reg_we && !cm_st_release && !flush_o && !lk_hit));

endmodule

// File: tb/rob_core_tb.sv
module rob_core_tb;

    localparam int DEPTH  = 8;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int TAG_W  = $clog2(DEPTH);

    typedef struct packed {
        logic              is_store;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
        logic [TAG_W-1:0]  tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [1:0]        alloc_kind = '0;
    logic [REG_W-1:0]  alloc_dest = '0;
    logic              alloc_ready;
    logic [TAG_W-1:0]  alloc_tag;
    logic              wb_valid = 1'b0;
    logic [TAG_W-1:0]  wb_tag = '0;
    logic [DATA_W-1:0] wb_value = '0;
    logic              wb_fault = 1'b0;
    logic [REG_W-1:0]  lk_reg = '0;
    logic              lk_hit, lk_ready;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_value;
    logic              cm_reg_we, cm_st_release;
    logic [REG_W-1:0]  cm_dest;
    logic [DATA_W-1:0] cm_value;
    logic [TAG_W-1:0]  cm_tag;
    logic              flush_o;
    logic [TAG_W-1:0]  flush_tag;

    always #2 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_dut (.*);

    int checks = 0, errors = 0;
    int next_tag = 0;
    int commits_seen = 0, flushes_seen = 0;
    bit flush_armed = 0;
    logic [TAG_W-1:0] flush_exp = '0;
    bit running = 0, finished = 0;
    exp_t exp_q[$];
    logic [DATA_W-1:0] val_of [DEPTH];

    task automatic check_eq(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic issue(input logic [1:0] kind, input logic [REG_W-1:0] dest, input logic [DATA_W-1:0] value);
        exp_t e;
        @(negedge clk);
        alloc_valid = 1'b1; alloc_kind = kind; alloc_dest = dest;
        #1;
        check_eq("R3", "alloc_ready on free slot", DATA_W'(alloc_ready), 1);
        check_eq("R2", "alloc_tag sequence and wrap", DATA_W'(alloc_tag), DATA_W'(next_tag));
        val_of[alloc_tag] = value;
        if (kind != 2'd2) begin
            e.is_store = (kind == 2'd1); e.dest = dest; e.value = value; e.tag = alloc_tag;
            exp_q.push_back(e);
        end
        next_tag = (next_tag + 1) % DEPTH;
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic wb_raw(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] value, input logic fault);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = tag; wb_value = value; wb_fault = fault;
        @(posedge clk); #1;
        wb_valid = 1'b0; wb_fault = 1'b0;
    endtask

    task automatic wb(input logic [TAG_W-1:0] tag, input logic fault);
        wb_raw(tag, val_of[tag], fault);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(string req);
        for (int k = 0; k < 40 && exp_q.size() != 0; k++) @(negedge clk);
        idle(1);
        check_eq(req, "all expected retirements seen", DATA_W'(exp_q.size()), 0);
    endtask

    // monitor: compares each retirement and flush against the scoreboard
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (flush_o) begin
                flushes_seen++;
                check_eq("R8", "flush expected", DATA_W'(flush_armed), 1);
                check_eq("R8", "flush_tag", DATA_W'(flush_tag), DATA_W'(flush_exp));
                check_eq("R8", "no write during flush", DATA_W'({cm_reg_we, cm_st_release}), 0);
                exp_q.delete();
                flush_armed = 0;
                next_tag = 0;
            end
            if (cm_reg_we || cm_st_release) begin
                commits_seen++;
                if (exp_q.size() == 0) begin
                    check_eq("R5", "unexpected retirement tag", DATA_W'(cm_tag), '1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check_eq("R6", "store release vs reg write", DATA_W'({cm_st_release, cm_reg_we}),
                             e.is_store ? 2 : 1);
                    check_eq("R5", "retire tag in program order", DATA_W'(cm_tag), DATA_W'(e.tag));
                    check_eq("R5", "retire value", cm_value, e.value);
                    if (!e.is_store) check_eq("R5", "retire dest", DATA_W'(cm_dest), DATA_W'(e.dest));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0, f0, start;
        logic [TAG_W-1:0] ta, tb, tc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk); #1;
        check_eq("R1", "alloc_ready", DATA_W'(alloc_ready), 1);
        check_eq("R1", "alloc_tag", DATA_W'(alloc_tag), 0);
        check_eq("R1", "commit/flush idle", DATA_W'({cm_reg_we, cm_st_release, flush_o}), 0);
        check_eq("R1", "lk_hit", DATA_W'(lk_hit), 0);
        running = 1;

        // R5: in-order return
        issue(2'd0, 5'd1, 32'h1111_0001);
        issue(2'd0, 5'd2, 32'h1111_0002);
        issue(2'd0, 5'd3, 32'h1111_0003);
        wb(0, 0); wb(1, 0); wb(2, 0);
        drain("R5");

        // R4: reverse-order return, head waits
        issue(2'd0, 5'd4, 32'h2222_0003);
        issue(2'd0, 5'd5, 32'h2222_0004);
        issue(2'd0, 5'd6, 32'h2222_0005);
        issue(2'd0, 5'd7, 32'h2222_0006);
        c0 = commits_seen;
        wb(6, 0); wb(5, 0); wb(4, 0);
        idle(2);
        check_eq("R4", "no retirement while head pending", DATA_W'(commits_seen - c0), 0);
        wb(3, 0);
        drain("R4");
        check_eq("R4", "all four retired", DATA_W'(commits_seen - c0), 4);

        // R6 / R7: store, branch, register mix
        issue(2'd1, 5'd0, 32'h5700_0007);
        issue(2'd2, 5'd0, 32'h0);
        issue(2'd0, 5'd9, 32'h3333_0001);
        c0 = commits_seen;
        wb(1, 0); wb(0, 0); wb(7, 0);
        drain("R6");
        check_eq("R7", "branch retires silently", DATA_W'(commits_seen - c0), 2);

        // R3 / R2: fill, refuse, retire, wrap
        start = next_tag;
        for (int k = 0; k < DEPTH; k++) issue(2'd0, REG_W'(10 + k), 32'h4400_0000 + k);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd31;
        #1 check_eq("R3", "alloc_ready when full", DATA_W'(alloc_ready), 0);
        @(posedge clk); #1 alloc_valid = 1'b0;
        wb(TAG_W'(start), 0);
        idle(2);
        issue(2'd0, 5'd20, 32'h4400_00ff);
        for (int k = 1; k <= DEPTH; k++) wb(TAG_W'((start + k) % DEPTH), 0);
        drain("R3");

        // R11: lookup of youngest producer
        ta = TAG_W'(next_tag);
        issue(2'd0, 5'd7, 32'h7000_00aa);
        tb = TAG_W'(next_tag);
        issue(2'd0, 5'd7, 32'h7000_00bb);
        tc = TAG_W'(next_tag);
        issue(2'd0, 5'd9, 32'h7000_00cc);
        @(negedge clk); lk_reg = 5'd7; #1;
        check_eq("R11", "lk_hit", DATA_W'(lk_hit), 1);
        check_eq("R11", "lk_ready before result", DATA_W'(lk_ready), 0);
        check_eq("R11", "youngest producer tag", DATA_W'(lk_tag), DATA_W'(tb));
        lk_reg = 5'd3; #1;
        check_eq("R11", "miss on idle register", DATA_W'(lk_hit), 0);
        wb(tb, 0);
        @(negedge clk); lk_reg = 5'd7; #1;
        check_eq("R11", "lk_ready after result", DATA_W'(lk_ready), 1);
        check_eq("R11", "lk_value", lk_value, 32'h7000_00bb);
        wb(ta, 0); wb(tc, 0);
        drain("R11");
        @(negedge clk); #1;
        check_eq("R11", "miss after retirement", DATA_W'(lk_hit), 0);

        // R10: stray writeback
        ta = TAG_W'(next_tag);
        issue(2'd0, 5'd12, 32'h0c0c_0001);
        wb_raw(TAG_W'((ta + 1) % DEPTH), 32'hdead_beef, 0);
        tb = TAG_W'(next_tag);
        issue(2'd0, 5'd13, 32'h0d0d_0001);
        @(negedge clk); lk_reg = 5'd13; #1;
        check_eq("R10", "slot hit after stray wb", DATA_W'(lk_hit), 1);
        check_eq("R10", "slot not complete after stray wb", DATA_W'(lk_ready), 0);
        wb(ta, 0); wb(tb, 0);
        drain("R10");

        // R8: fault at head
        ta = TAG_W'(next_tag);
        issue(2'd0, 5'd4, 32'h8800_0001);
        tb = TAG_W'(next_tag);
        issue(2'd0, 5'd5, 32'h8800_0002);
        wb(tb, 0);
        c0 = commits_seen; f0 = flushes_seen;
        flush_armed = 1; flush_exp = ta;
        wb(ta, 1);
        idle(3);
        check_eq("R8", "one flush", DATA_W'(flushes_seen - f0), 1);
        check_eq("R8", "no retirement around flush", DATA_W'(commits_seen - c0), 0);
        lk_reg = 5'd5; #1;
        check_eq("R8", "buffer empty after flush", DATA_W'(lk_hit), 0);
        issue(2'd0, 5'd6, 32'h8800_0003);
        wb(0, 0);
        drain("R8");

        // R9: younger fault waits for older retirements
        ta = TAG_W'(next_tag);
        issue(2'd0, 5'd1, 32'h9900_0001);
        tb = TAG_W'(next_tag);
        issue(2'd1, 5'd0, 32'h9900_0002);
        tc = TAG_W'(next_tag);
        issue(2'd0, 5'd2, 32'h9900_0003);
        c0 = commits_seen; f0 = flushes_seen;
        wb(tc, 0);
        wb(tb, 1);
        idle(2);
        check_eq("R9", "no flush before fault reaches head", DATA_W'(flushes_seen - f0), 0);
        flush_armed = 1; flush_exp = tb;
        wb(ta, 0);
        idle(4);
        check_eq("R9", "older slot retired", DATA_W'(commits_seen - c0), 1);
        check_eq("R9", "flush after older retirement", DATA_W'(flushes_seen - f0), 1);

        running = 0;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule